// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters. It oversamples the incoming line at 16 or 8 samples per bit and finds each start bit. It then assembles 5 to 9 data bits, least significant first, followed by an optional parity bit and one stop bit. Each finished character is stored together with its own frame, parity and overrun flags. Those flags stay attached to the character as it moves through a two-entry queue, so the flags seen at the read port always describe the character shown there.

A consumer reads the head of the queue. One pulse on the pop input takes that character away. A valid flag stays high for as long as any unread character remains. A registered interrupt output combines that flag with a local enable and a global enable. An address-filtering mode can be set. In that mode, 9-bit frames whose ninth bit is clear are discarded before they reach the queue. Clearing the enable input empties the queue and the pending character at once.

Top module: `uart_rx_buffered`

## Requirements
- R1: A frame is one low start bit, then the data bits least significant first, then a parity bit when `par_en` is 1, then one stop bit. The number of data bits comes from `char_bits`: codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and codes 4 to 7 select 9 bits. `rd_data` holds the received bits right-aligned, with the unused upper bits at 0.
- R2: At most two characters wait in the queue. The head and its flags hold steady until `rd_pop` is pulsed while `rd_valid` is 1. Each such pulse removes exactly one character, and characters leave in arrival order.
- R3: A character that completes while the queue is full waits in a single hold stage. A start bit confirmed while the queue is full and the hold stage is occupied sets `rd_dor` on the held character, and the frame that follows is discarded.
- R4: `rd_fe` is 1 for a character whose stop bit was sampled as 0, and 0 when the stop bit was 1. The character is stored in both cases.
- R5: `rd_pe` is 1 only when `par_en` was 1 for that frame and the parity bit did not match. Even parity is selected by `par_odd`=0, meaning the data bits XOR the parity bit equals 0. Odd parity is selected by `par_odd`=1.
- R6: With `dbl_speed`=0 a bit lasts 16 sample ticks; with `dbl_speed`=1 it lasts 8 sample ticks. A sample tick occurs once every `baud_div`+1 clocks.
- R7: Every bit value is the 2-of-3 majority of samples 8, 9 and 10 (16x) or samples 4, 5 and 6 (8x), counted from the falling edge. A start bit whose majority is high is dropped, and the receiver returns to idle without storing anything.
- R8: When `mpc_mode` is 1 and 9 data bits are selected, a frame whose ninth bit is 0 never enters the queue. A frame whose ninth bit is 1 is stored normally.
- R9: A clock edge with `rx_en` at 0 empties the queue and the hold stage. After that edge, `rd_valid`, `rd_fe`, `rd_pe` and `rd_dor` read 0.
- R10: `irq` is a register. It is 1 exactly one clock after a cycle in which `rxc_ie`, `gie` and `rd_valid` were all 1.
- R11: `rd_valid` is 1 exactly while at least one unread character sits in the queue. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; 0 flushes all stored characters |
| rx_line | input | 1 | Serial input line, idle high |
| baud_div | input | PRESC_W | Sample tick every baud_div+1 clocks |
| dbl_speed | input | 1 | 1 selects 8 samples per bit instead of 16 |
| char_bits | input | 3 | Data-bit count code (see R1) |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 selects odd parity |
| mpc_mode | input | 1 | Address filtering on the ninth bit |
| rxc_ie | input | 1 | Local receive interrupt enable |
| gie | input | 1 | Global interrupt enable |
| rd_pop | input | 1 | Remove the head character |
| rd_data | output | 9 | Head character data |
| rd_fe | output | 1 | Head character frame error |
| rd_pe | output | 1 | Head character parity error |
| rd_dor | output | 1 | Head character overrun marker |
| rd_valid | output | 1 | At least one unread character |
| irq | output | 1 | Registered receive interrupt |

## Verification
The assertions assume three things about the inputs. First, `rd_pop` is pulsed only toward a valid head. Second, every drop of the valid flag comes from a pop or from a disable. Third, the frame configuration and the line rate stay fixed for the whole length of a frame. The stimulus respects this. It changes `char_bits`, parity, speed and filtering only while the line is idle. It drives every bit for exactly 16 or 8 times (`baud_div`+1) clocks, and it issues pops only from a task that first checks for a stored character. The false-start glitch is kept shorter than half a bit, so it is rejected by the majority vote and not by the synchronizer.

// File: rtl/urx_pkg.sv
`timescale 1ns/1ps
package urx_pkg;
   localparam int unsigned MAXB = 9;

   typedef struct packed {
      logic [MAXB-1:0] data;
      logic            fe;
      logic            pe;
      logic            dor;
   } rx_char_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } urx_state_e;
endpackage

// File: rtl/urx_tick_gen.sv
`timescale 1ns/1ps
module urx_tick_gen #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] div,
   output logic         tick
);
   generate
      if (W < 1) begin : g_bad_w
         $error("urx_tick_gen: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign tick = en && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/urx_frame_fsm.sv
`timescale 1ns/1ps
module urx_frame_fsm
   import urx_pkg::*;
#(
   parameter int unsigned OSR_NORM    = 16,
   parameter int unsigned OSR_FAST    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic       rx_raw,
   input  logic       dbl_speed,
   input  logic [2:0] char_bits,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       mpc_mode,
   output logic       start_evt,
   output logic       done,
   output rx_char_t   done_char
);
   localparam int unsigned SCW = $clog2(OSR_NORM + 1);

   generate
      if (OSR_FAST < 4 || OSR_FAST >= OSR_NORM || (OSR_NORM % 2) != 0 || (OSR_FAST % 2) != 0) begin : g_bad_osr
         $error("urx_frame_fsm: oversampling ratios must be even, fast >= 4 and fast < normal");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("urx_frame_fsm: at least one synchronizer stage required");
      end
   endgenerate

   // line synchronizer
   logic [SYNC_STAGES-1:0] sync_q;
   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= rx_raw;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_raw};
         end
      end
   endgenerate

   logic rx_s;
   assign rx_s = sync_q[SYNC_STAGES-1];

   urx_state_e      st;
   logic [SCW-1:0]  scnt, scnt_nx, osr, mid0, mid1, mid2;
   logic [1:0]      votes;
   logic [3:0]      bidx, len;
   logic [MAXB-1:0] shreg;
   logic            par_acc, par_bad, prev, bit_maj, accept;

   assign osr     = dbl_speed ? SCW'(OSR_FAST) : SCW'(OSR_NORM);
   assign mid0    = osr >> 1;
   assign mid1    = mid0 + 1'b1;
   assign mid2    = mid0 + 2'd2;
   assign scnt_nx = scnt + 1'b1;
   assign len     = (char_bits >= 3'd4) ? 4'd9 : ({1'b0, char_bits} + 4'd5);
   assign bit_maj = (votes[1] & votes[0]) | (votes[1] & rx_s) | (votes[0] & rx_s);
   assign accept  = !(mpc_mode && (len == 4'd9) && !shreg[MAXB-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         scnt      <= '0;
         votes     <= '0;
         bidx      <= '0;
         shreg     <= '0;
         par_acc   <= 1'b0;
         par_bad   <= 1'b0;
         prev      <= 1'b1;
         start_evt <= 1'b0;
         done      <= 1'b0;
         done_char <= '0;
      end else begin
         prev      <= rx_s;
         start_evt <= 1'b0;
         done      <= 1'b0;
         if (!en) begin
            st <= ST_IDLE;
         end else if (st == ST_IDLE) begin
            if (prev && !rx_s) begin
               st      <= ST_START;
               scnt    <= '0;
               bidx    <= '0;
               shreg   <= '0;
               par_acc <= 1'b0;
               par_bad <= 1'b0;
            end
         end else if (tick) begin
            scnt <= scnt_nx;
            if (scnt_nx == mid0 || scnt_nx == mid1) votes <= {votes[0], rx_s};
            if (scnt_nx == mid2) begin
               case (st)
                  ST_START: begin
                     if (bit_maj) st <= ST_IDLE;
                     else         start_evt <= 1'b1;
                  end
                  ST_DATA: begin
                     shreg[bidx] <= bit_maj;
                     par_acc     <= par_acc ^ bit_maj;
                     bidx        <= bidx + 1'b1;
                  end
                  ST_PAR: par_bad <= bit_maj ^ par_acc ^ par_odd;
                  ST_STOP: begin
                     st        <= ST_IDLE;
                     done      <= accept;
                     done_char <= '{data: shreg, fe: !bit_maj, pe: par_en & par_bad, dor: 1'b0};
                  end
                  default: ;
               endcase
            end
            if (scnt_nx == osr) begin
               scnt <= '0;
               case (st)
                  ST_START: st <= ST_DATA;
                  ST_DATA:  if (bidx == len) st <= par_en ? ST_PAR : ST_STOP;
                  ST_PAR:   st <= ST_STOP;
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/urx_char_queue.sv
`timescale 1ns/1ps
module urx_char_queue
   import urx_pkg::*;
#(
   parameter  int unsigned DEPTH = 2,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  rx_char_t      push_char,
   input  logic          start_evt,
   input  logic          pop,
   output rx_char_t      head,
   output logic          head_valid,
   output logic [CW-1:0] level
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("urx_char_queue: DEPTH must be at least 1");
      end
   endgenerate

   rx_char_t      ent [DEPTH];
   rx_char_t      hold;
   logic          hold_v;
   logic [CW-1:0] count, cnt_ap;
   logic          do_pop, drain, take, ovr;

   assign do_pop = pop && (count != '0);
   assign cnt_ap = count - CW'(do_pop);
   assign drain  = hold_v && (cnt_ap < CW'(DEPTH));
   assign take   = push && (!hold_v || drain);
   assign ovr    = start_evt && hold_v && !drain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (flush) count <= '0;
      else            count <= cnt_ap + CW'(drain);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold   <= '0;
         hold_v <= 1'b0;
      end else if (flush) begin
         hold_v <= 1'b0;
      end else if (take) begin
         hold   <= push_char;
         hold_v <= 1'b1;
      end else if (drain) begin
         hold_v <= 1'b0;
      end else if (ovr) begin
         hold.dor <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (drain && cnt_ap == CW'(i))        ent[i] <= hold;
            else if (do_pop && i < int'(DEPTH) - 1) ent[i] <= ent[i+1];
         end
      end
   end

   assign head       = ent[0];
   assign head_valid = (count != '0);
   assign level      = count;
endmodule

// File: rtl/uart_rx_buffered.sv
`timescale 1ns/1ps
module uart_rx_buffered
   import urx_pkg::*;
#(
   parameter  int unsigned PRESC_W     = 12,
   parameter  int unsigned DEPTH       = 2,
   parameter  int unsigned OSR_NORM    = 16,
   parameter  int unsigned OSR_FAST    = 8,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned LVL_W       = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_en,
   input  logic               rx_line,
   input  logic [PRESC_W-1:0] baud_div,
   input  logic               dbl_speed,
   input  logic [2:0]         char_bits,
   input  logic               par_en,
   input  logic               par_odd,
   input  logic               mpc_mode,
   input  logic               rxc_ie,
   input  logic               gie,
   input  logic               rd_pop,
   output logic [MAXB-1:0]    rd_data,
   output logic               rd_fe,
   output logic               rd_pe,
   output logic               rd_dor,
   output logic               rd_valid,
   output logic               irq
);
   logic             tick, start_evt, done, hv;
   rx_char_t         done_char, head;
   logic [LVL_W-1:0] q_level;

   urx_tick_gen #(.W(PRESC_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rx_en),
      .div  (baud_div),
      .tick (tick)
   );

   urx_frame_fsm #(
      .OSR_NORM   (OSR_NORM),
      .OSR_FAST   (OSR_FAST),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (rx_en),
      .tick     (tick),
      .rx_raw   (rx_line),
      .dbl_speed(dbl_speed),
      .char_bits(char_bits),
      .par_en   (par_en),
      .par_odd  (par_odd),
      .mpc_mode (mpc_mode),
      .start_evt(start_evt),
      .done     (done),
      .done_char(done_char)
   );

   urx_char_queue #(.DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (!rx_en),
      .push      (done),
      .push_char (done_char),
      .start_evt (start_evt),
      .pop       (rd_pop),
      .head      (head),
      .head_valid(hv),
      .level     (q_level)
   );

   assign rd_valid = hv;
   assign rd_data  = hv ? head.data : '0;
   assign rd_fe    = hv & head.fe;
   assign rd_pe    = hv & head.pe;
   assign rd_dor   = hv & head.dor;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= rxc_ie & gie & hv;
   end
endmodule

// File: rtl/urx_checker.sv
`timescale 1ns/1ps
module urx_checker #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned LVL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_en,
   input logic             rd_pop,
   input logic             rd_valid,
   input logic [8:0]       rd_data,
   input logic             rd_fe,
   input logic             rd_pe,
   input logic             rd_dor,
   input logic             rxc_ie,
   input logic             gie,
   input logic             irq,
   input logic [LVL_W-1:0] q_level
);
   p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= LVL_W'(DEPTH));

   p_head_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_pop && rx_en) |=> (rd_valid && $stable(rd_data) && $stable(rd_fe)
                                           && $stable(rd_pe)));

   p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (!rd_valid && !rd_fe && !rd_pe && !rd_dor));

   p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(gie && rxc_ie) |=> !irq);

   p_irq_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(rd_valid));

   p_rise_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(rx_en));

   p_fall_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_valid) |-> ($past(rd_pop) || !$past(rx_en)));
endmodule

bind uart_rx_buffered urx_checker #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rx_en   (rx_en),
   .rd_pop  (rd_pop),
   .rd_valid(rd_valid),
   .rd_data (rd_data),
   .rd_fe   (rd_fe),
   .rd_pe   (rd_pe),
   .rd_dor  (rd_dor),
   .rxc_ie  (rxc_ie),
   .gie     (gie),
   .irq     (irq),
   .q_level (q_level)
);

// File: tb/uart_rx_buffered_tb.sv
`timescale 1ns/1ps
module uart_rx_buffered_tb;
   logic        clk = 1'b0, rst_n = 1'b0, rx_en = 1'b1, rx_line = 1'b1;
   logic [11:0] baud_div = 12'd1;
   logic        dbl_speed = 1'b0, par_en = 1'b0, par_odd = 1'b0, mpc_mode = 1'b0;
   logic [2:0]  char_bits = 3'd3;
   logic        rxc_ie = 1'b1, gie = 1'b1, rd_pop = 1'b0;
   logic [8:0]  rd_data;
   logic        rd_fe, rd_pe, rd_dor, rd_valid, irq;

   always #10 clk = ~clk;

   uart_rx_buffered u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_line(rx_line), .baud_div(baud_div),
      .dbl_speed(dbl_speed), .char_bits(char_bits), .par_en(par_en), .par_odd(par_odd),
      .mpc_mode(mpc_mode), .rxc_ie(rxc_ie), .gie(gie), .rd_pop(rd_pop), .rd_data(rd_data),
      .rd_fe(rd_fe), .rd_pe(rd_pe), .rd_dor(rd_dor), .rd_valid(rd_valid), .irq(irq)
   );

   typedef struct { logic [8:0] data; bit fe; bit pe; bit dor; } ent_t;
   ent_t mq[$];
   ent_t mh;
   bit   mh_v = 0;
   bit   in_sync = 1;
   bit   prev_irq = 0;
   int   nchk = 0, nerr = 0;
   int   cfg_bits = 8;
   bit   done_flag = 0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_drain();
      if (mh_v && mq.size() < 2) begin
         mq.push_back(mh);
         mh_v = 0;
      end
   endtask

   // cycle monitor: irq one clock behind the ports (R10), queue view (R2, R11)
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         check(irq == prev_irq, "R10 irq", irq, prev_irq);
         if (in_sync) begin
            check(rd_valid == (mq.size() > 0), "R11 valid", rd_valid, mq.size() > 0);
            if (mq.size() > 0)
               check({rd_data, rd_fe, rd_pe, rd_dor} == {mq[0].data, mq[0].fe, mq[0].pe, mq[0].dor},
                     "R2 head", {rd_data, rd_fe, rd_pe, rd_dor},
                     {mq[0].data, mq[0].fe, mq[0].pe, mq[0].dor});
         end
      end
      prev_irq = rst_n && rxc_ie && gie && rd_valid;
   end

   task automatic drv();
      @(posedge clk);
      #2;
   endtask

   task automatic line_bit(input bit b, input int len);
      rx_line = b;
      repeat (len) @(posedge clk);
      #2;
   endtask

   task automatic send(input int data, input bit bad_par, input bit stop_v);
      int   len;
      bit   p;
      ent_t e;
      len = (dbl_speed ? 8 : 16) * (int'(baud_div) + 1);
      in_sync = 0;
      if (mq.size() == 2 && mh_v) mh.dor = 1;
      line_bit(1'b0, len);
      p = 0;
      for (int i = 0; i < cfg_bits; i++) begin
         p ^= data[i];
         line_bit(data[i], len);
      end
      if (par_en) line_bit(p ^ par_odd ^ bad_par, len);
      line_bit(stop_v, len);
      rx_line = 1'b1;
      repeat (2 * len + 4) @(posedge clk);
      #2;
      e.data = 9'(data & ((1 << cfg_bits) - 1));
      e.fe   = !stop_v;
      e.pe   = par_en && bad_par;
      e.dor  = 0;
      if (!(mpc_mode && cfg_bits == 9 && !data[8])) begin
         model_drain();
         if (!mh_v) begin
            mh = e;
            mh_v = 1;
         end
         model_drain();
      end
      in_sync = 1;
   endtask

   task automatic set_bits(input int n);
      cfg_bits  = n;
      char_bits = (n >= 9) ? 3'd4 : 3'(n - 5);
   endtask

   task automatic pop_check(input string tag, input int data, input bit fe, input bit pe, input bit dor);
      @(negedge clk);
      check(rd_valid, {tag, " present"}, rd_valid, 1);
      check({rd_data, rd_fe, rd_pe, rd_dor} == {9'(data), fe, pe, dor}, tag,
            {rd_data, rd_fe, rd_pe, rd_dor}, {9'(data), fe, pe, dor});
      drv();
      rd_pop = 1'b1;
      drv();
      rd_pop = 1'b0;
      if (mq.size() > 0) void'(mq.pop_front());
      model_drain();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (4) drv();
      rst_n = 1'b1;
      drv();
      @(negedge clk);
      check(!rd_valid && !irq && !rd_fe && !rd_pe && !rd_dor, "R11 reset", {rd_valid, irq}, 0);
      drv();

      // R1: 8, 5 and 9 data bits, LSB first
      set_bits(8);  send(8'hA5, 0, 1);  pop_check("R1 8bit", 9'h0A5, 0, 0, 0);
      set_bits(5);  send(8'h33, 0, 1);  pop_check("R1 5bit", 9'h013, 0, 0, 0);
      set_bits(9);  send(9'h1C3, 0, 1); pop_check("R1 9bit", 9'h1C3, 0, 0, 0);
      set_bits(7);  send(8'h7E, 0, 1);  pop_check("R1 7bit", 9'h07E, 0, 0, 0);

      // R6: double speed
      set_bits(8);
      dbl_speed = 1'b1;
      send(8'h5A, 0, 1); pop_check("R6 8x", 9'h05A, 0, 0, 0);
      baud_div = 12'd2;
      send(8'hC1, 0, 1); pop_check("R6 8x div2", 9'h0C1, 0, 0, 0);
      dbl_speed = 1'b0;
      baud_div = 12'd1;

      // R5: parity good, odd bad, even bad
      par_en = 1'b1;
      send(8'h17, 0, 1); pop_check("R5 even ok", 9'h017, 0, 0, 0);
      par_odd = 1'b1;
      send(8'h17, 1, 1); pop_check("R5 odd bad", 9'h017, 0, 1, 0);
      send(8'h80, 0, 1); pop_check("R5 odd ok", 9'h080, 0, 0, 0);
      par_odd = 1'b0;
      send(8'h0F, 1, 1); pop_check("R5 even bad", 9'h00F, 0, 1, 0);
      par_en = 1'b0;

      // R4: stop bit low
      send(8'h3C, 0, 0); pop_check("R4 fe", 9'h03C, 1, 0, 0);
      send(8'h3D, 0, 1); pop_check("R4 no fe", 9'h03D, 0, 0, 0);

      // R7: short low glitch rejected, then a normal frame
      rx_line = 1'b0;
      repeat (6) @(posedge clk);
      #2;
      rx_line = 1'b1;
      repeat (80) drv();
      @(negedge clk);
      check(!rd_valid, "R7 false start", rd_valid, 0);
      drv();
      send(8'h99, 0, 1); pop_check("R7 recover", 9'h099, 0, 0, 0);

      // R8: address filtering
      set_bits(9);
      mpc_mode = 1'b1;
      send(9'h0FF, 0, 1);
      @(negedge clk);
      check(!rd_valid, "R8 drop", rd_valid, 0);
      drv();
      send(9'h155, 0, 1); pop_check("R8 accept", 9'h155, 0, 0, 0);
      mpc_mode = 1'b0;
      set_bits(8);

      // R10: interrupt gating
      send(8'h42, 0, 1);
      gie = 1'b0;
      drv(); drv();
      @(negedge clk);
      check(!irq, "R10 gie off", irq, 0);
      drv();
      gie = 1'b1;
      rxc_ie = 1'b0;
      drv(); drv();
      @(negedge clk);
      check(!irq, "R10 ie off", irq, 0);
      drv();
      rxc_ie = 1'b1;
      drv(); drv();
      @(negedge clk);
      check(irq, "R10 on", irq, 1);
      drv();
      pop_check("R10 char", 9'h042, 0, 0, 0);

      // R2 and R3: fill queue and hold, then overrun
      send(8'h01, 0, 1);
      send(8'h02, 0, 1);
      send(8'h03, 0, 1);
      send(8'h04, 0, 1);
      pop_check("R2 first", 9'h001, 0, 0, 0);
      pop_check("R2 second", 9'h002, 0, 0, 0);
      pop_check("R3 overrun", 9'h003, 0, 0, 1);
      @(negedge clk);
      check(!rd_valid, "R3 lost frame", rd_valid, 0);
      drv();

      // R9: flush
      send(8'h11, 0, 0);
      send(8'h12, 0, 1);
      rx_en = 1'b0;
      drv();
      mq.delete();
      mh_v = 0;
      rx_en = 1'b1;
      @(negedge clk);
      check(!rd_valid && !rd_fe && !rd_pe && !rd_dor, "R9 flush", {rd_valid, rd_fe}, 0);
      drv();
      send(8'h6E, 0, 1); pop_check("R9 after", 9'h06E, 0, 0, 0);

      repeat (4) drv();
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule